// File: doc/BRIEF.md
# Prescaled Match Timer

A 32-bit up-counter, clocked either through a programmable prescaler or by falling edges on an external input. Four compare channels watch the count. Each channel has three actions that software turns on separately: raise a sticky status flag, return the count to zero, or halt counting and drop the run bit. All control, compare and counter state is reached through a single-cycle register port. That port has separate write and read addresses, and the read path is combinational.

A *step* is a clock on which the main count would advance. In clock mode, a step happens when the prescale counter equals the prescale limit while running. In edge mode, a step happens on a detected falling edge of `cap_in` while running. A channel *fires* on a step when the count equals that channel's compare value. All actions of a firing channel take effect on that same edge.

Top module: `ptimer_top`

## Requirements
- R1: While the run bit (CTRL bit 0) is 0, neither COUNT nor PSCNT changes, except through a software write or the clear control.
- R2: Writing 1 to CTRL bit 1 sets the clear control. On the next edge COUNT and PSCNT become 0 and the bit returns to 0, so it reads 1 for exactly one cycle. No step occurs while it is set.
- R3: In clock mode (MODE not equal to 2), PSCNT counts 0..PSCALE while running. On the clock where PSCNT equals PSCALE, PSCNT wraps to 0 and COUNT increments, so COUNT advances once every PSCALE+1 clocks and on every clock when PSCALE is 0.
- R4: In edge mode (MODE = 2), `cap_in` passes through a two-stage synchronizer. COUNT increments once per falling edge, two edges after the input changes. PSCNT holds.
- R5: When channel i fires and its flag action bit (MACT bit 3i) is 1, flag bit i of FLAGS becomes 1 on the same edge.
- R6: When a firing channel has its zeroing action bit (MACT bit 3i+1) set, COUNT becomes 0 instead of incrementing.
- R7: When a firing channel has its halt action bit (MACT bit 3i+2) set, COUNT and PSCNT hold and the run bit clears. Halt wins over zeroing.
- R8: A write to FCLR clears each FLAGS bit written as 1 and leaves bits written as 0 unchanged. A flag being set on the same edge wins over its clear. FLAGS ignores writes, and FCLR reads 0.
- R9: Software writes to COUNT and PSCNT load them directly and win over stepping, clearing and halting. A CTRL write wins over a halt. All registers are 0 after reset.
- R10: The word addresses are: 0 CTRL, 1 COUNT, 2 PSCALE, 3 PSCNT, 4 MODE (bits 1:0), 5 MACT, 6..9 compare values 0..3, 10 FLAGS (bits 3:0), 11 FCLR. Unused register bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Word address of the read |
| rd_data | output | 32 | Read data, combinational on rd_addr |
| cap_in | input | 1 | Asynchronous event input counted in edge mode |

## Verification
A corrupted prescale count or main count shows at the ports within one clock. It appears in the very next COUNT or PSCNT read, and a wrong prescale wrap shifts every later step of COUNT. A wrong fire decision leaves a trace on the edge after the step: a flag in FLAGS, a zeroed or held COUNT, or a dropped run bit in CTRL. Every register is read and compared on every cycle, so a divergence is caught in the cycle it appears rather than at the end of a sequence.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

  localparam int A_CTRL   = 0;
  localparam int A_COUNT  = 1;
  localparam int A_PSCALE = 2;
  localparam int A_PSCNT  = 3;
  localparam int A_MODE   = 4;
  localparam int A_MACT   = 5;
  localparam int A_MATCH0 = 6;

  localparam logic [1:0] MODE_EDGE = 2'd2;

  typedef struct packed {
    logic halt;
    logic zero;
    logic flag;
  } mact_t;

endpackage

// File: rtl/ptimer_regs.sv
module ptimer_regs
  import ptimer_pkg::*;
#(
  parameter int W   = 32,
  parameter int NCH = 4,
  parameter int AW  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [W-1:0]            wr_data,
  input  logic [AW-1:0]           rd_addr,
  input  logic [W-1:0]            tc,
  input  logic [W-1:0]            pc,
  input  logic                    stop_evt,
  input  logic [NCH-1:0]          flag_set,
  output logic                    run,
  output logic                    clr_pend,
  output logic                    edge_mode,
  output logic [W-1:0]            pre,
  output mact_t [NCH-1:0]         mact,
  output logic [NCH-1:0][W-1:0]   mr,
  output logic                    wr_tc,
  output logic                    wr_pc,
  output logic [W-1:0]            rd_data
);

  localparam int A_FLAGS = A_MATCH0 + NCH;
  localparam int A_FCLR  = A_MATCH0 + NCH + 1;

  logic [1:0]     mode_q;
  logic [NCH-1:0] flags_q;
  logic [NCH-1:0] fclr_mask;
  logic           wr_ctrl;
  logic           wr_fclr;

  assign wr_ctrl   = wr_en && (wr_addr == AW'(A_CTRL));
  assign wr_fclr   = wr_en && (wr_addr == AW'(A_FCLR));
  assign wr_tc     = wr_en && (wr_addr == AW'(A_COUNT));
  assign wr_pc     = wr_en && (wr_addr == AW'(A_PSCNT));
  assign fclr_mask = wr_fclr ? wr_data[NCH-1:0] : '0;
  assign edge_mode = (mode_q == MODE_EDGE);

  function automatic logic [NCH-1:0] f_flags_next(input logic [NCH-1:0] cur,
                                                  input logic [NCH-1:0] clr,
                                                  input logic [NCH-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      clr_pend <= 1'b0;
      mode_q   <= '0;
      pre      <= '0;
      mact     <= '0;
      mr       <= '0;
      flags_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        run      <= wr_data[0];
        clr_pend <= wr_data[1];
      end else begin
        clr_pend <= 1'b0;
        if (stop_evt) run <= 1'b0;
      end
      if (wr_en && wr_addr == AW'(A_PSCALE)) pre    <= wr_data;
      if (wr_en && wr_addr == AW'(A_MODE))   mode_q <= wr_data[1:0];
      if (wr_en && wr_addr == AW'(A_MACT))   mact   <= wr_data[3*NCH-1:0];
      for (int i = 0; i < NCH; i++) begin
        if (wr_en && wr_addr == AW'(A_MATCH0 + i)) mr[i] <= wr_data;
      end
      flags_q <= f_flags_next(flags_q, fclr_mask, flag_set);
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(A_CTRL))   rd_data[1:0] = {clr_pend, run};
    if (rd_addr == AW'(A_COUNT))  rd_data = tc;
    if (rd_addr == AW'(A_PSCALE)) rd_data = pre;
    if (rd_addr == AW'(A_PSCNT))  rd_data = pc;
    if (rd_addr == AW'(A_MODE))   rd_data[1:0] = mode_q;
    if (rd_addr == AW'(A_MACT))   rd_data[3*NCH-1:0] = mact;
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == AW'(A_MATCH0 + i)) rd_data = mr[i];
    end
    if (rd_addr == AW'(A_FLAGS))  rd_data[NCH-1:0] = flags_q;
  end

  assert_clr_self_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pend && !wr_ctrl) |=> !clr_pend);

  assert_halt_drops_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !wr_ctrl) |=> !run);

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set != '0) |=> ((flags_q & $past(flag_set)) == $past(flag_set)));

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fclr && flag_set == '0) |=> ((flags_q & $past(wr_data[NCH-1:0])) == '0));

endmodule

// File: rtl/ptimer_match.sv
module ptimer_match
  import ptimer_pkg::*;
#(
  parameter int W   = 32,
  parameter int NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [W-1:0]          tc,
  input  logic                  adv,
  input  logic [NCH-1:0][W-1:0] mr,
  input  mact_t [NCH-1:0]       mact,
  output logic [NCH-1:0]        hit,
  output logic [NCH-1:0]        flag_set,
  output logic                  stop_req,
  output logic                  rst_req
);

  logic [NCH-1:0] halt_vec;
  logic [NCH-1:0] zero_vec;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign hit[g]      = adv && (tc == mr[g]);
    assign flag_set[g] = hit[g] && mact[g].flag;
    assign halt_vec[g] = hit[g] && mact[g].halt;
    assign zero_vec[g] = hit[g] && mact[g].zero;
  end

  assign stop_req = |halt_vec;
  assign rst_req  = |zero_vec;

  assert_fire_needs_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set != '0) |-> adv);

endmodule

// File: rtl/ptimer_count.sv
module ptimer_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clr_pend,
  input  logic         edge_mode,
  input  logic [W-1:0] pre,
  input  logic         cap_in,
  input  logic         wr_tc,
  input  logic         wr_pc,
  input  logic [W-1:0] wr_data,
  input  logic         stop_req,
  input  logic         rst_req,
  output logic [W-1:0] tc,
  output logic [W-1:0] pc,
  output logic         adv
);

  logic [2:0] sync_q;
  logic       fall;

  function automatic logic [W-1:0] f_pc_after(input logic [W-1:0] pc_v,
                                              input logic [W-1:0] pre_v);
    return (pc_v == pre_v) ? '0 : pc_v + W'(1);
  endfunction

  function automatic logic [W-1:0] f_tc_after(input logic [W-1:0] tc_v,
                                              input logic halt_v,
                                              input logic zero_v);
    if (halt_v) return tc_v;
    if (zero_v) return '0;
    return tc_v + W'(1);
  endfunction

  assign fall = sync_q[2] && !sync_q[1];
  assign adv  = run && !clr_pend && (edge_mode ? fall : (pc == pre));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      tc     <= '0;
      pc     <= '0;
    end else begin
      sync_q <= {sync_q[1:0], cap_in};
      if (wr_pc)
        pc <= wr_data;
      else if (clr_pend)
        pc <= '0;
      else if (run && !edge_mode && !(adv && stop_req))
        pc <= f_pc_after(pc, pre);
      if (wr_tc)
        tc <= wr_data;
      else if (clr_pend)
        tc <= '0;
      else if (adv)
        tc <= f_tc_after(tc, stop_req, rst_req);
    end
  end

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr_pend && !wr_tc) |=> $stable(tc));

  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pend && !wr_tc && !wr_pc) |=> (tc == '0 && pc == '0));

  assert_step_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !stop_req && !rst_req && !wr_tc) |=> (tc == $past(tc) + W'(1)));

  assert_edge_pc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !clr_pend && !wr_pc) |=> $stable(pc));

  assert_zero_on_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && rst_req && !stop_req && !wr_tc) |=> (tc == '0));

  assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && stop_req && !wr_tc && !wr_pc) |=> ($stable(tc) && $stable(pc)));

endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
  import ptimer_pkg::*;
#(
  parameter int W   = 32,
  parameter int NCH = 4,
  parameter int AW  = $clog2(A_MATCH0 + NCH + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic          cap_in
);

  logic                  run;
  logic                  clr_pend;
  logic                  edge_mode;
  logic [W-1:0]          pre;
  mact_t [NCH-1:0]       mact;
  logic [NCH-1:0][W-1:0] mr;
  logic                  wr_tc;
  logic                  wr_pc;
  logic [W-1:0]          tc;
  logic [W-1:0]          pc;
  logic                  adv;
  logic [NCH-1:0]        hit;
  logic [NCH-1:0]        flag_set;
  logic                  stop_req;
  logic                  rst_req;

  ptimer_regs #(.W(W), .NCH(NCH), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .tc(tc), .pc(pc), .stop_evt(stop_req), .flag_set(flag_set),
    .run(run), .clr_pend(clr_pend), .edge_mode(edge_mode), .pre(pre), .mact(mact),
    .mr(mr), .wr_tc(wr_tc), .wr_pc(wr_pc), .rd_data(rd_data)
  );

  ptimer_count #(.W(W)) u_count (
    .clk(clk), .rst_n(rst_n), .run(run), .clr_pend(clr_pend), .edge_mode(edge_mode),
    .pre(pre), .cap_in(cap_in), .wr_tc(wr_tc), .wr_pc(wr_pc), .wr_data(wr_data),
    .stop_req(stop_req), .rst_req(rst_req), .tc(tc), .pc(pc), .adv(adv)
  );

  ptimer_match #(.W(W), .NCH(NCH)) u_match (
    .clk(clk), .rst_n(rst_n), .tc(tc), .adv(adv), .mr(mr), .mact(mact),
    .hit(hit), .flag_set(flag_set), .stop_req(stop_req), .rst_req(rst_req)
  );

endmodule

// File: tb/ptimer_top_tb.sv
module ptimer_top_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CLK_PERIOD = 20;
  localparam int W   = 32;
  localparam int NCH = 4;
  localparam int AW  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [W-1:0]  rd_data;
  logic          cap_in = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptimer_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cap_in(cap_in)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string phase = "R9 reset";
  bit    cap_lvl = 1'b0;

  // reference state
  logic        m_run, m_clr;
  logic [1:0]  m_mode;
  logic [31:0] m_pre, m_tc, m_pc;
  logic [11:0] m_mact;
  logic [31:0] m_mr [4];
  logic [3:0]  m_flags;
  logic        q1, q2, q3;

  task automatic model_reset();
    m_run = 0; m_clr = 0; m_mode = 0; m_pre = 0; m_tc = 0; m_pc = 0;
    m_mact = 0; m_flags = 0; q1 = 0; q2 = 0; q3 = 0;
    for (int i = 0; i < 4; i++) m_mr[i] = 0;
  endtask

  function automatic logic [31:0] exp_rd(int a);
    case (a)
      0: return {30'd0, m_clr, m_run};
      1: return m_tc;
      2: return m_pre;
      3: return m_pc;
      4: return {30'd0, m_mode};
      5: return {20'd0, m_mact};
      6, 7, 8, 9: return m_mr[a-6];
      10: return {28'd0, m_flags};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0: return "R2";
      1, 3: return "R3";
      10, 11: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string req, int a, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] addr %0d: actual %h expected %h", req, phase, a, act, exp);
    end
  endtask

  task automatic check_all();
    for (int a = 0; a < 12; a++) begin
      rd_addr = a[3:0];
      #0.5;
      chk(tag_of(a), a, rd_data, exp_rd(a));
    end
  endtask

  // one clock: drive at negedge, compare, predict, commit after posedge
  task automatic cyc(bit we, int wa, logic [31:0] wd);
    logic        fall, em, adv, st, rs;
    logic [3:0]  fl;
    logic        n_run, n_clr;
    logic [31:0] n_tc, n_pc;
    wr_en = we; wr_addr = wa[3:0]; wr_data = wd; cap_in = cap_lvl;
    check_all();
    fall = q3 & ~q2;
    em   = (m_mode == 2'd2);
    adv  = m_run & ~m_clr & (em ? fall : (m_pc == m_pre));
    st = 0; rs = 0; fl = 0;
    for (int i = 0; i < 4; i++) begin
      if (adv && m_tc == m_mr[i]) begin
        fl[i] = m_mact[3*i];
        rs = rs | m_mact[3*i+1];
        st = st | m_mact[3*i+2];
      end
    end
    if (we && wa == 1) n_tc = wd;
    else if (m_clr) n_tc = 0;
    else if (adv) n_tc = st ? m_tc : (rs ? 32'd0 : m_tc + 1);
    else n_tc = m_tc;
    if (we && wa == 3) n_pc = wd;
    else if (m_clr) n_pc = 0;
    else if (m_run && !em && !st) n_pc = (m_pc == m_pre) ? 32'd0 : m_pc + 1;
    else n_pc = m_pc;
    if (we && wa == 0) begin n_run = wd[0]; n_clr = wd[1]; end
    else begin n_run = st ? 1'b0 : m_run; n_clr = 1'b0; end
    @(posedge clk);
    q3 = q2; q2 = q1; q1 = cap_lvl;
    m_tc = n_tc; m_pc = n_pc; m_run = n_run; m_clr = n_clr;
    if (we && wa == 2) m_pre = wd;
    if (we && wa == 4) m_mode = wd[1:0];
    if (we && wa == 5) m_mact = wd[11:0];
    if (we && wa >= 6 && wa <= 9) m_mr[wa-6] = wd;
    m_flags = (m_flags & ~((we && wa == 11) ? wd[3:0] : 4'd0)) | fl;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 [watchdog]: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    phase = "R9 reset";
    check_all();

    phase = "R1 idle hold";
    cyc(1, 1, 32'd5);
    cyc(1, 3, 32'd2);
    idle(4);

    phase = "R3 prescale zero";
    cyc(1, 3, 0);
    cyc(1, 0, 32'd1);
    idle(6);

    phase = "R3 prescale three";
    cyc(1, 0, 0);
    cyc(1, 2, 32'd3);
    cyc(1, 1, 0);
    cyc(1, 0, 32'd1);
    idle(10);
    chk("R3", 1, m_tc, 32'd2);

    phase = "R2 clear control";
    cyc(1, 0, 32'd3);
    idle(3);

    phase = "R5 R6 flag and zero";
    cyc(1, 2, 0);
    cyc(1, 6, 32'd4);
    cyc(1, 5, 32'b011);
    cyc(1, 0, 32'd3);
    idle(15);

    phase = "R8 clear flags";
    cyc(1, 11, 0);
    cyc(1, 11, 32'hF);
    cyc(1, 10, 32'hF);
    idle(2);

    phase = "R7 halt over zero";
    cyc(1, 7, 32'd7);
    cyc(1, 5, 32'b111_000);
    cyc(1, 0, 32'd3);
    idle(12);
    chk("R7", 0, {31'd0, m_run}, 32'd0);

    phase = "R4 edge mode";
    cyc(1, 5, 0);
    cyc(1, 4, 32'd2);
    cyc(1, 1, 0);
    cyc(1, 0, 32'd1);
    for (int k = 0; k < 10; k++) begin
      cap_lvl = ~cap_lvl;
      idle(3);
    end

    phase = "R9 R10 random";
    for (int n = 0; n < 3000; n++) begin
      bit          we;
      int          wa;
      logic [31:0] wd;
      we = ($urandom % 5) == 0;
      wa = $urandom % 12;
      case (wa)
        0: wd = {30'd0, ($urandom % 8) == 0, ($urandom % 5) != 0};
        1, 6, 7, 8, 9: wd = $urandom % 41;
        2, 3: wd = $urandom % 4;
        4: wd = $urandom % 4;
        5: wd = $urandom % 4096;
        default: wd = $urandom;
      endcase
      if (($urandom % 3) == 0) cap_lvl = ~cap_lvl;
      cyc(we, wa, wd);
    end

    finish_run();
  end

endmodule